// File: doc/BRIEF.md
# Per-Area Bus Wait-State Sequencer

This block paces external bus cycles for five address areas, numbered 0 to 4. Each area has its own settings:

- a wait code that sets how many cycles each beat is stretched;
- an idle code that sets the quiet gap after a completed access;
- a data-path width;
- a bit that tells the block whether to obey or ignore the external WAIT pin.

Area 4 also has a delay code. The delay cycles are added before the WAIT pin is sampled.

The CPU side offers a request with an area number, a read/write flag, a size code and a two-bit byte offset. The block accepts it when it is ready. It then drives one strobe beat, or several back-to-back beats when the access is wider than the area's data path. Each beat carries its own byte-lane enables and byte offset. A one-cycle acknowledge marks the final cycle of the final beat.

The three configuration words are assumed to be set up already by software. The block reads them only at the moment it accepts a request. It does no address decoding, generates no memory commands and models no pin timing. It only counts cycles and steps through beats.

Top module: `bus_wait_seq`

## Requirements
- R1: While reset is held low and after it is released with no request pending, req_ready is 1 and req_ack, bus_strobe, bus_write, bus_lanes and bus_off are all 0.
- R2: The wait code sets the cycles added to each beat. Codes 0, 1 and 2 add 0, 1 and 2 cycles. Code 3 adds LONG_WAIT cycles (default 4). With WAIT ignored and no delay, a beat keeps bus_strobe high for 1 + added cycles.
- R3: After the acknowledge, req_ready stays low for 0, 1, 2 or 4 cycles for idle codes 0, 1, 2 and 3, then returns high.
- R4: For area N in 0 to 3, wait_word_a holds the wait code at bits [2N+1:2N] and the idle code at bits [2N+9:2N+8]. Area 4 takes its wait code from wait_word_b[1:0] and its idle code from wait_word_b[3:2].
- R5: wait_word_b bit 8+N is the WAIT mask of area N. When the bit is clear, a beat whose added cycles have all elapsed is extended for every cycle in which wait_in is 1. When the bit is set, wait_in has no effect on timing.
- R6: For area 4 with its mask bit clear, wait_word_b[15:14] adds 0, 1, 4 or 4 cycles to every beat, for codes 0, 1, 2 and 3. When the mask bit is set, or for any other area, nothing is added.
- R7: Widths and beat count:
  - For area N in 1 to 4, bus_word bits [2N-1:2N-2] select the data-path width: 1 is 8-bit, 2 is 16-bit, and 3 or 0 is 32-bit.
  - Area 0 is always 32-bit.
  - req_size 0, 1, 2 and 3 mean 1, 2, 4 and 4 bytes.
  - An access takes size/width beats, with a minimum of one.
- R8: The beats of one access follow each other with no gap. req_ack is 1 only in the final cycle of the final beat, and bus_strobe is 0 in the cycle after it.
- R9: Lane i carries data bits [8i+7:8i]. The request offset is first aligned down to the access size. A byte at offset k goes on lane (k mod width) for little-endian, or lane (width-1-(k mod width)) for big-endian. bus_word bit 8 makes area 2 little-endian and bit 9 makes area 4 little-endian. All other areas are big-endian.
- R10: During a beat, bus_off equals (aligned offset + beat index × width bytes) mod 4, and bus_write equals the latched write flag. Both are 0 outside beats.
- R11: A request is taken only in a cycle where req_ready and req_valid are both 1. Its fields and the configuration words are captured in that cycle. Later changes to either do not affect the running access.
- R12: Area numbers 5 to 7 are treated exactly like area 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wait_word_a | input | 16 | Wait and idle codes for areas 0 to 3 |
| wait_word_b | input | 16 | Area 4 wait, idle and delay codes, plus the WAIT mask bits |
| bus_word | input | 16 | Width codes for areas 1 to 4 and the endian bits |
| req_valid | input | 1 | Request present |
| req_area | input | 3 | Target area number |
| req_write | input | 1 | 1 for a write access |
| req_size | input | 2 | Access size code |
| req_off | input | 2 | Byte offset of the access |
| req_ready | output | 1 | Block is able to accept a request |
| req_ack | output | 1 | Final cycle of the access |
| bus_strobe | output | 1 | A beat is in progress |
| bus_write | output | 1 | Write indication during a beat |
| bus_lanes | output | 4 | Byte-lane enables of the current beat |
| bus_off | output | 2 | Byte offset of the current beat |
| wait_in | input | 1 | External wait request |

## Verification
Timing is tested by sweeping each code on its own:

- all four wait codes with WAIT masked;
- all four idle codes;
- all four area 4 delay codes.

Any error in the code-to-count tables therefore appears as a latency or gap off by a known amount. WAIT pulses of different lengths are applied with the mask set and with it clear, on area 1 and on area 4. This separates a stall that starts after the added cycles from one applied too early, too late or regardless of the mask.

Lane mapping is tested with byte, half-word and word accesses at every offset, on 8-, 16- and 32-bit paths and under both byte orders. These expose errors in beat counting, beat offset stepping and endian reversal. Further accesses cover:

- changing the configuration mid-access;
- area numbers above 4;
- width code 0.

// File: rtl/bws_pkg.sv
package bws_pkg;

   localparam int AREA_CNT = 5;
   localparam int AREA_W   = $clog2(AREA_CNT);
   localparam int WORD_W   = 16;
   localparam int LANE_CNT = 4;
   localparam int OFF_W    = $clog2(LANE_CNT);

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BEAT = 2'd1,
      ST_GAP  = 2'd2
   } seq_state_t;

   typedef struct packed {
      logic [1:0] wait_code;
      logic [1:0] idle_code;
      logic [1:0] width_code;
      logic [1:0] delay_code;
      logic       wait_masked;
      logic       little;
   } area_cfg_t;

   // Added cycles per beat for a wait code.
   function automatic int wait_len(input logic [1:0] code, input int long_len);
      return (code == 2'd3) ? long_len : int'(code);
   endfunction

   // Gap cycles after an access for an idle code.
   function automatic int idle_len(input logic [1:0] code);
      return (code == 2'd3) ? 4 : int'(code);
   endfunction

   // Extra cycles for the area 4 delay code.
   function automatic int delay_len(input logic [1:0] code);
      case (code)
         2'd0:    return 0;
         2'd1:    return 1;
         default: return 4;
      endcase
   endfunction

   // log2 of the data-path width in bytes.
   function automatic logic [1:0] width_log(input logic [1:0] code);
      case (code)
         2'd1:    return 2'd0;
         2'd2:    return 2'd1;
         default: return 2'd2;
      endcase
   endfunction

endpackage

// File: rtl/bws_area_sel.sv
module bws_area_sel
   import bws_pkg::*;
(
   input  logic [WORD_W-1:0] wait_word_a,
   input  logic [WORD_W-1:0] wait_word_b,
   input  logic [WORD_W-1:0] bus_word,
   input  logic [AREA_W-1:0] area,
   output area_cfg_t         cfg
);

   area_cfg_t tbl [AREA_CNT];

   for (genvar g = 0; g < AREA_CNT; g++) begin : g_area
      logic [1:0] w_c, i_c, d_c, wd_c;
      logic       lt_c;

      if (g < 4) begin : g_word_a
         assign w_c = wait_word_a[2*g+1 -: 2];
         assign i_c = wait_word_a[2*g+9 -: 2];
         assign d_c = 2'b00;
      end else begin : g_word_b
         assign w_c = wait_word_b[1:0];
         assign i_c = wait_word_b[3:2];
         assign d_c = wait_word_b[15:14];
      end

      if (g == 0) begin : g_fixed_width
         assign wd_c = 2'b11;
      end else begin : g_prog_width
         assign wd_c = bus_word[2*g-1 -: 2];
      end

      if (g == 2) begin : g_end_a2
         assign lt_c = bus_word[8];
      end else if (g == 4) begin : g_end_a4
         assign lt_c = bus_word[9];
      end else begin : g_end_big
         assign lt_c = 1'b0;
      end

      assign tbl[g] = '{wait_code:   w_c,
                        idle_code:   i_c,
                        width_code:  wd_c,
                        delay_code:  d_c,
                        wait_masked: wait_word_b[8+g],
                        little:      lt_c};
   end

   logic [AREA_W-1:0] idx;
   always_comb begin
      idx = (int'(area) < AREA_CNT) ? area : '0;
      cfg = tbl[idx];
   end

   logic unused_cfg_bits;
   assign unused_cfg_bits = ^{wait_word_b[7:4], wait_word_b[13], bus_word[15:10]};

endmodule

// File: rtl/bws_lane_map.sv
module bws_lane_map #(
   parameter int LANES = 4,
   localparam int OW = $clog2(LANES)
) (
   input  logic [1:0]       width_log,
   input  logic [1:0]       size_log,
   input  logic [OW-1:0]    base_off,
   input  logic [OW-1:0]    beat,
   input  logic             little,
   output logic [LANES-1:0] lanes,
   output logic [OW-1:0]    byte_off
);

   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("bws_lane_map: LANES must be a power of two of at least 2");
   end

   always_comb begin
      int nb_log, bytes, bw, pos, shift, off_i, aligned;
      nb_log  = (size_log < width_log) ? int'(size_log) : int'(width_log);
      bytes   = 1 << nb_log;
      bw      = 1 << width_log;
      aligned = int'(base_off) & ~((1 << size_log) - 1);
      off_i   = (aligned + (int'(beat) << width_log)) % LANES;
      pos     = off_i % bw;
      shift   = little ? pos : (bw - pos - bytes);
      lanes   = LANES'(((1 << bytes) - 1) << shift);
      byte_off = OW'(off_i);
   end

endmodule

// File: rtl/bws_down_cnt.sv
module bws_down_cnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         zero
);

   if (W < 1) begin : g_bad_w
      $error("bws_down_cnt: W must be positive");
   end

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                   cnt <= '0;
      else if (load)                cnt <= load_val;
      else if (dec && cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/bus_wait_seq.sv
module bus_wait_seq
   import bws_pkg::*;
#(
   parameter int LONG_WAIT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] wait_word_a,
   input  logic [WORD_W-1:0] wait_word_b,
   input  logic [WORD_W-1:0] bus_word,
   input  logic              req_valid,
   input  logic [AREA_W-1:0] req_area,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [OFF_W-1:0]  req_off,
   output logic              req_ready,
   output logic              req_ack,
   output logic              bus_strobe,
   output logic              bus_write,
   output logic [LANE_CNT-1:0] bus_lanes,
   output logic [OFF_W-1:0]  bus_off,
   input  logic              wait_in
);

   localparam int MAX_BEAT = LONG_WAIT + 4;
   localparam int CW       = $clog2(MAX_BEAT + 1);

   if (LONG_WAIT < 3 || LONG_WAIT > 1000) begin : g_bad_long
      $error("bus_wait_seq: LONG_WAIT must lie between 3 and 1000");
   end

   function automatic logic [CW-1:0] beat_load(input area_cfg_t c);
      int v;
      v = wait_len(c.wait_code, LONG_WAIT) + (c.wait_masked ? 0 : delay_len(c.delay_code));
      return CW'(v);
   endfunction

   seq_state_t       state;
   area_cfg_t        sel_cfg, cfg_r;
   logic             wr_r;
   logic [1:0]       size_log_r;
   logic [OFF_W-1:0] off_r, beat_r;

   bws_area_sel i_sel (
      .wait_word_a (wait_word_a),
      .wait_word_b (wait_word_b),
      .bus_word    (bus_word),
      .area        (req_area),
      .cfg         (sel_cfg)
   );

   logic [1:0] wlog_r;
   logic       last_beat, cnt_zero, stall, beat_done, accept;
   logic       cnt_load;
   logic [CW-1:0] cnt_val;

   always_comb begin
      int nbl;
      wlog_r    = width_log(cfg_r.width_code);
      nbl       = (size_log_r > wlog_r) ? int'(size_log_r) - int'(wlog_r) : 0;
      last_beat = (int'(beat_r) == (1 << nbl) - 1);
   end

   assign accept    = (state == ST_IDLE) && req_valid;
   assign stall     = (state == ST_BEAT) && cnt_zero && !cfg_r.wait_masked && wait_in;
   assign beat_done = (state == ST_BEAT) && cnt_zero && !stall;

   always_comb begin
      cnt_load = 1'b0;
      cnt_val  = '0;
      if (accept) begin
         cnt_load = 1'b1;
         cnt_val  = beat_load(sel_cfg);
      end else if (beat_done && !last_beat) begin
         cnt_load = 1'b1;
         cnt_val  = beat_load(cfg_r);
      end else if (beat_done && idle_len(cfg_r.idle_code) != 0) begin
         cnt_load = 1'b1;
         cnt_val  = CW'(idle_len(cfg_r.idle_code) - 1);
      end
   end

   bws_down_cnt #(.W(CW)) i_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cnt_val),
      .dec      (state != ST_IDLE),
      .zero     (cnt_zero)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cfg_r      <= '0;
         wr_r       <= 1'b0;
         size_log_r <= '0;
         off_r      <= '0;
         beat_r     <= '0;
      end else begin
         case (state)
            ST_IDLE: if (accept) begin
               state      <= ST_BEAT;
               cfg_r      <= sel_cfg;
               wr_r       <= req_write;
               size_log_r <= (req_size == 2'd3) ? 2'd2 : req_size;
               off_r      <= req_off;
               beat_r     <= '0;
            end
            ST_BEAT: if (beat_done) begin
               if (!last_beat)                             beat_r <= beat_r + 1'b1;
               else if (idle_len(cfg_r.idle_code) != 0)    state  <= ST_GAP;
               else                                        state  <= ST_IDLE;
            end
            ST_GAP: if (cnt_zero) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   logic [LANE_CNT-1:0] map_lanes;
   logic [OFF_W-1:0]    map_off;

   bws_lane_map #(.LANES(LANE_CNT)) i_map (
      .width_log (wlog_r),
      .size_log  (size_log_r),
      .base_off  (off_r),
      .beat      (beat_r),
      .little    (cfg_r.little),
      .lanes     (map_lanes),
      .byte_off  (map_off)
   );

   assign req_ready  = (state == ST_IDLE);
   assign bus_strobe = (state == ST_BEAT);
   assign req_ack    = beat_done && last_beat;
   assign bus_write  = bus_strobe && wr_r;
   assign bus_lanes  = bus_strobe ? map_lanes : '0;
   assign bus_off    = bus_strobe ? map_off : '0;

endmodule

// File: rtl/bws_checker.sv
module bws_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       req_ready,
   input logic       req_ack,
   input logic       bus_strobe,
   input logic       bus_write,
   input logic [3:0] bus_lanes
);

   assert_reset_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (req_ready && !bus_strobe));

   assert_ready_no_beat_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_ready && bus_strobe));

   assert_fall_starts_beat_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_ready) |-> bus_strobe);

   assert_ack_in_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |-> bus_strobe);

   assert_ack_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> !bus_strobe);

   assert_lanes_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_strobe |-> (bus_lanes == 4'd0));

   assert_lanes_present_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_strobe |-> (bus_lanes != 4'd0));

   assert_write_in_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_write |-> bus_strobe);

endmodule

bind bus_wait_seq bws_checker i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .req_ack    (req_ack),
   .bus_strobe (bus_strobe),
   .bus_write  (bus_write),
   .bus_lanes  (bus_lanes)
);

// File: tb/test_bus_wait_seq.sv
module test_bus_wait_seq;

   localparam int LONGW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [15:0] wait_word_a, wait_word_b, bus_word;
   logic req_valid = 1'b0, req_write = 1'b0, wait_in = 1'b0;
   logic [2:0] req_area = '0;
   logic [1:0] req_size = '0, req_off = '0;
   logic req_ready, req_ack, bus_strobe, bus_write;
   logic [3:0] bus_lanes;
   logic [1:0] bus_off;

   always #10 clk = ~clk;

   bus_wait_seq #(.LONG_WAIT(LONGW)) i_bus_wait_seq (.*);

   int checks = 0, errors = 0;

   // bench-side configuration truth
   int  wcode[5], icode[5], wdcode[5], dcode;
   bit  msk[5], lit2, lit4;

   task automatic pack();
      wait_word_a = '0; wait_word_b = '0; bus_word = '0;
      for (int n = 0; n < 4; n++) begin
         wait_word_a[2*n +: 2]   = 2'(wcode[n]);
         wait_word_a[2*n+8 +: 2] = 2'(icode[n]);
      end
      wait_word_b[1:0]   = 2'(wcode[4]);
      wait_word_b[3:2]   = 2'(icode[4]);
      wait_word_b[15:14] = 2'(dcode);
      for (int n = 0; n < 5; n++) wait_word_b[8+n] = msk[n];
      for (int n = 1; n < 5; n++) bus_word[2*n-2 +: 2] = 2'(wdcode[n]);
      bus_word[8] = lit2;
      bus_word[9] = lit4;
   endtask

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic int map_area(input int a); return (a > 4) ? 0 : a; endfunction
   function automatic int wbytes(input int a);
      if (a == 0) return 4;
      case (wdcode[a]) 1: return 1; 2: return 2; default: return 4; endcase
   endfunction
   function automatic int sbytes(input int s); return (s == 0) ? 1 : (s == 1) ? 2 : 4; endfunction
   function automatic int wcount(input int c); return (c == 3) ? LONGW : c; endfunction
   function automatic int icount(input int c); return (c == 3) ? 4 : c; endfunction
   function automatic int dcount(input int c); return (c == 0) ? 0 : (c == 1) ? 1 : 4; endfunction
   function automatic int beat_len(input int a);
      return wcount(wcode[a]) + ((a == 4 && !msk[4]) ? dcount(dcode) : 0) + 1;
   endfunction

   // ---------------- reference model, one step per clock ----------------
   int m_ph, m_left, m_beat, m_nb, m_load, m_idle, m_wb, m_sb, m_al;
   bit m_mask, m_little, m_wr;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_left = 0; m_beat = 0;
      end else begin
         case (m_ph)
            0: if (req_valid) begin
               int a;
               a        = map_area(int'(req_area));
               m_wb     = wbytes(a);
               m_sb     = sbytes(int'(req_size));
               m_nb     = (m_sb > m_wb) ? m_sb / m_wb : 1;
               m_load   = beat_len(a) - 1;
               m_idle   = icount(icode[a]);
               m_mask   = msk[a];
               m_little = (a == 2) ? lit2 : (a == 4) ? lit4 : 1'b0;
               m_wr     = req_write;
               m_al     = int'(req_off) - (int'(req_off) % m_sb);
               m_left   = m_load; m_beat = 0; m_ph = 1;
            end
            1: if (m_left > 0) m_left--;
               else if (m_mask || !wait_in) begin
                  if (m_beat == m_nb - 1) begin
                     if (m_idle > 0) begin m_ph = 2; m_left = m_idle - 1; end
                     else m_ph = 0;
                  end else begin
                     m_beat++; m_left = m_load;
                  end
               end
            default: if (m_left == 0) m_ph = 0; else m_left--;
         endcase
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         bit e_stb, e_ack;
         int e_lanes, e_off, e_wr;
         e_stb = (m_ph == 1);
         e_ack = e_stb && m_left == 0 && (m_mask || !wait_in) && m_beat == m_nb - 1;
         e_lanes = 0; e_off = 0; e_wr = 0;
         if (e_stb) begin
            int off, p, n, sh;
            off = (m_al + m_beat * m_wb) % 4;
            p   = off % m_wb;
            n   = (m_sb < m_wb) ? m_sb : m_wb;
            sh  = m_little ? p : (m_wb - p - n);
            e_lanes = ((1 << n) - 1) << sh;
            e_off = off; e_wr = m_wr;
         end
         chk(bus_strobe == e_stb, "R2", "strobe", int'(bus_strobe), int'(e_stb));
         chk(req_ready == (m_ph == 0), "R3", "ready", int'(req_ready), int'(m_ph == 0));
         chk(req_ack == e_ack, "R8", "ack", int'(req_ack), int'(e_ack));
         chk(int'(bus_lanes) == e_lanes, "R9", "lanes", int'(bus_lanes), e_lanes);
         chk(int'(bus_off) == e_off, "R10", "offset", int'(bus_off), e_off);
         chk(int'(bus_write) == e_wr, "R10", "write", int'(bus_write), e_wr);
      end
   end

   // ---------------- directed accesses ----------------
   task automatic run_access(input int area, input int wr, input int size, input int off,
                             input int k, input bit scramble, input string tag);
      int a, bl, nb, exp_lat, exp_gap, n, g;
      a  = map_area(area);
      bl = beat_len(a);
      nb = (sbytes(size) > wbytes(a)) ? sbytes(size) / wbytes(a) : 1;
      if (msk[a]) exp_lat = nb * bl;
      else        exp_lat = ((bl > k + 1) ? bl : k + 1) + (nb - 1) * bl;
      exp_gap = icount(icode[a]);
      @(posedge clk); #2;
      g = 0;
      while (!req_ready && g < 50) begin @(posedge clk); #2; g++; end
      req_valid = 1'b1; req_area = 3'(area); req_write = 1'(wr);
      req_size = 2'(size); req_off = 2'(off);
      @(posedge clk); #2;
      req_valid = 1'b0;
      if (scramble) begin
         for (int i = 0; i < 5; i++) begin wcode[i] = 3; icode[i] = 3; wdcode[i] = 1; msk[i] = 0; end
         dcode = 2; pack();
         wait_in = 1'b0;
      end
      n = 1;
      forever begin
         wait_in = (n <= k);
         @(negedge clk);
         if (req_ack || n > 300) break;
         @(posedge clk); #2;
         n++;
      end
      chk(n == exp_lat, tag, "latency", n, exp_lat);
      @(posedge clk); #2; wait_in = 1'b0;
      g = 0;
      @(negedge clk);
      while (!req_ready && g < 50) begin g++; @(negedge clk); end
      chk(g == exp_gap, tag, "gap", g, exp_gap);
   endtask

   task automatic base_cfg();
      for (int i = 0; i < 5; i++) begin wcode[i] = 0; icode[i] = 0; wdcode[i] = 3; msk[i] = 1; end
      dcode = 0; lit2 = 0; lit4 = 0;
      pack();
   endtask

   int cycles = 0;
   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      base_cfg();
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(req_ready && !bus_strobe && !req_ack && bus_lanes == 0 && !bus_write && bus_off == 0,
          "R1", "reset outputs", int'({req_ready, bus_strobe, req_ack}), 4);
      @(posedge clk); #2 rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !bus_strobe && bus_lanes == 0, "R1", "post-reset idle",
          int'({req_ready, bus_strobe}), 2);

      // R2: wait codes on area 0
      for (int c = 0; c < 4; c++) begin
         wcode[0] = c; pack(); run_access(0, 0, 2, 0, 0, 0, "R2");
      end
      // R3: idle codes on area 1
      base_cfg();
      for (int c = 0; c < 4; c++) begin
         icode[1] = c; pack(); run_access(1, 1, 2, 0, 0, 0, "R3");
      end
      // R4: field placement, area 3 and area 4
      base_cfg(); wcode[3] = 2; icode[3] = 1; wcode[4] = 1; icode[4] = 2; pack();
      run_access(3, 0, 2, 0, 0, 0, "R4");
      run_access(4, 1, 2, 0, 0, 0, "R4");
      // R5: WAIT masked vs honoured
      base_cfg(); wcode[1] = 1; pack();
      run_access(1, 0, 2, 0, 5, 0, "R5");
      msk[1] = 0; pack();
      run_access(1, 0, 2, 0, 5, 0, "R5");
      run_access(1, 0, 2, 0, 1, 0, "R5");
      // R6: area 4 delay codes
      base_cfg(); msk[4] = 0;
      for (int c = 0; c < 4; c++) begin
         dcode = c; pack(); run_access(4, 0, 2, 0, 0, 0, "R6");
      end
      dcode = 1; pack(); run_access(4, 0, 2, 0, 3, 0, "R6");
      msk[4] = 1; dcode = 2; pack(); run_access(4, 0, 2, 0, 3, 0, "R6");
      // R7 / R9 / R10: widths, sizes, offsets, byte order
      base_cfg(); wdcode[1] = 1; wdcode[2] = 2; wdcode[3] = 2; wdcode[4] = 0; wcode[1] = 1; pack();
      for (int e = 0; e < 2; e++) begin
         lit2 = 1'(e); lit4 = 1'(e); pack();
         for (int ar = 0; ar < 5; ar++)
            for (int s = 0; s < 3; s++)
               for (int o = 0; o < 4; o++)
                  run_access(ar, (o + s) % 2, s, o, 0, 0, "R7");
      end
      run_access(2, 1, 3, 2, 0, 0, "R9");
      // R12: out-of-range areas
      base_cfg(); wcode[0] = 2; icode[0] = 1; pack();
      for (int ar = 5; ar < 8; ar++) run_access(ar, 0, 1, 2, 0, 0, "R12");
      // R11: configuration changed after acceptance
      base_cfg(); wcode[2] = 1; wdcode[2] = 2; pack();
      run_access(2, 1, 2, 0, 3, 1, "R11");
      base_cfg();
      run_access(2, 0, 0, 3, 0, 0, "R11");

      repeat (4) @(posedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule